// File: doc/BRIEF.md
# Step Sequence Controller with Nested Loops

The controller walks a step memory of 4096 entries, one step at a time. Each 64-bit step word gives a command, a target address, a loop count, a loop counter index, a condition selector and a pattern length. A step stays current for its programmed number of pattern cycles. On its final cycle the command picks the next step: fall through, jump, conditional jump, loop back, subroutine call, return, pause or halt. The step memory sits outside the block. The block drives `step_addr`, and the memory returns the word for that address combinationally on `step_word`.

Any of four start sources begins a sequence at address 0. The start sources are a software strobe, a trigger bus line, an external event and an external trigger input. Sixteen independent loop counters allow nested loops, and a 16-entry return stack holds the addresses for subroutine calls. Conditions for jumps are an error flag, a timeout flag, the level of an external signal, and the rising or falling edge of that signal. Sync pulses mark the start of the sequence and the start of each step.

Top module: `pattern_seq`

## Requirements
- R1: During and after reset the block is idle: `seq_idle`=1, `seq_active`=0, `step_active`=0, `step_addr`=0, `sos_pulse`=0, `step_sync`=0, `err_halt`=0.
- R2: A one-cycle pulse on any of `sw_start`, `trig_bus_start`, `ext_event_start` or `ext_trig_start` seen while idle starts the sequence at address 0 on the next cycle. That cycle carries `sos_pulse` and `step_sync` for one cycle, clears `err_halt`, and resets all loop counters and the return stack. A start seen while running or paused is ignored.
- R3: Step word fields: bits [2:0] command, [14:3] target, [30:15] loop count, [34:31] loop counter index, [37:35] condition, [63:38] pattern length L. A step is current for L+1 cycles. Command 0 (next) then moves to address+1, wrapping from 4095 to 0.
- R4: Command 1 (jump) moves to the target.
- R5: Command 2 (conditional jump) moves to the target if the selected condition holds in the step's final cycle, and to address+1 otherwise. Condition codes: 0 error input high, 1 timeout input high, 2 signal high, 3 signal low, 4 signal rising edge, 5 signal falling edge; 6 and 7 never hold.
- R6: Command 3 (loop end) uses loop counter `index`. With count N from 1 to 65535, the loop end goes back to the target N-1 times and then falls through, so the body runs N times. The counter is then free to be used again. Count 0 loops back forever. The 16 counters are independent, so loops may nest.
- R7: Command 4 (call) pushes address+1 and moves to the target. Command 5 (return) pops and moves to the popped address. The stack is 16 deep. A call with 16 entries stacked, or a return with none, stops the sequence (idle) and sets `err_halt` until the next start.
- R8: Command 6 (pause): after its pattern cycles the step address is held with `step_active`=0 and `seq_active`=1 until a `resume` pulse. The sequence then moves to address+1 with `step_sync`. A `resume` at any other time is ignored.
- R9: Command 7 (halt): after its pattern cycles the block returns to idle and keeps the last step address.
- R10: `step_sync` is high for exactly the first cycle of every step, and only while a step is active.
- R11: `sig_in` passes through two synchronizing flops. Level conditions use the second stage. An edge is the second stage differing from a third, registered copy, so an edge condition holds for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_start | input | 1 | Software start strobe |
| trig_bus_start | input | 1 | Trigger bus start line |
| ext_event_start | input | 1 | External event start |
| ext_trig_start | input | 1 | External trigger input start |
| resume | input | 1 | Leaves the pause state |
| err_in | input | 1 | Error condition (synchronous) |
| tmo_in | input | 1 | Timeout condition (synchronous) |
| sig_in | input | 1 | Asynchronous external signal for level and edge conditions |
| step_word | input | 64 | Step memory word at `step_addr` |
| step_addr | output | 12 | Current step address |
| step_active | output | 1 | A step is executing its pattern cycles |
| seq_active | output | 1 | Sequence running or paused |
| seq_idle | output | 1 | Sequence idle |
| sos_pulse | output | 1 | Start-of-sequence pulse |
| step_sync | output | 1 | Start-of-step pulse |
| err_halt | output | 1 | Stopped on a stack overflow or underflow |

## Verification
The assertions check the invariants that hold on every cycle. The address does not move inside a step or during a pause. The step sync pulse occurs only with an active step. The start-of-sequence pulse follows an idle cycle and lands on address 0. The error flag is seen only while idle. The bench's scenarios are needed for the control-flow results. These include how many times each body runs under nested and re-armed loop counters, call and return through the stack, stack overflow after 16 nested calls, and underflow. They also cover holding in pause until resume, each condition code, and whether a single-cycle edge lands in the step's deciding cycle or one cycle early.

// File: rtl/pseq_pkg.sv
// Shared types for the step sequence controller: step word layout,
// command and condition codes, controller state.
package pseq_pkg;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 16;
    localparam int CTR_W  = 4;
    localparam int PLEN_W = 26;
    localparam int NUM_LOOPS = 1 << CTR_W;
    localparam int WORD_W = PLEN_W + 3 + CTR_W + CNT_W + ADDR_W + 3;

    typedef enum logic [2:0] {
        OP_NEXT, OP_JUMP, OP_CJMP, OP_LOOP, OP_CALL, OP_RET, OP_PAUSE, OP_HALT
    } op_e;

    typedef enum logic [2:0] {
        C_ERR, C_TMO, C_HIGH, C_LOW, C_RISE, C_FALL, C_NONE6, C_NONE7
    } cond_e;

    typedef struct packed {
        logic [PLEN_W-1:0] plen;
        cond_e             cond;
        logic [CTR_W-1:0]  ctr;
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] target;
        op_e               op;
    } step_t;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PAUSE} st_e;
endpackage

// File: rtl/pseq_cond.sv
// Condition evaluator: synchronizes the external signal through two flops,
// keeps a third registered copy for edge detection, and selects one of the
// condition sources. Assumes err_in and tmo_in are already synchronous.
module pseq_cond
    import pseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  err_in,
    input  logic  tmo_in,
    input  logic  sig_in,
    input  cond_e sel,
    output logic  hit
);
    logic sync1, sync2, sync_prev;

    // Synchronizer chain plus previous-value register for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1     <= 1'b0;
            sync2     <= 1'b0;
            sync_prev <= 1'b0;
        end else begin
            sync1     <= sig_in;
            sync2     <= sync1;
            sync_prev <= sync2;
        end
    end

    // Condition select.
    always_comb begin
        case (sel)
            C_ERR:   hit = err_in;
            C_TMO:   hit = tmo_in;
            C_HIGH:  hit = sync2;
            C_LOW:   hit = !sync2;
            C_RISE:  hit = sync2 && !sync_prev;
            C_FALL:  hit = !sync2 && sync_prev;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pseq_loops.sv
// Bank of independent loop counters. On a loop-end event for counter idx,
// an idle counter arms with count-2 remaining back-jumps (count 1 never
// arms); an armed counter decrements and disarms at zero. Count 0 always
// loops back. Assumes one loop-end event per cycle at most.
module pseq_loops #(
    parameter int N  = 16,
    parameter int CW = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ev,
    input  logic [IW-1:0] idx,
    input  logic [CW-1:0] count,
    output logic          back
);
    logic          armed [N];
    logic [CW-1:0] rem   [N];

    for (genvar k = 0; k < N; k++) begin : g_ctr
        // Per-counter arm / decrement / disarm.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                armed[k] <= 1'b0;
                rem[k]   <= '0;
            end else if (ev && idx == IW'(k) && count != '0) begin
                if (!armed[k]) begin
                    armed[k] <= (count != CW'(1));
                    rem[k]   <= count - CW'(2);
                end else if (rem[k] == '0) begin
                    armed[k] <= 1'b0;
                end else begin
                    rem[k]   <= rem[k] - CW'(1);
                end
            end
        end
    end

    // Loop-back decision for the selected counter.
    always_comb begin
        if (count == '0)     back = 1'b1;
        else if (!armed[idx]) back = (count != CW'(1));
        else                 back = (rem[idx] != '0);
    end
endmodule

// File: rtl/pseq_stack.sv
// Return-address stack. Push and pop are ignored when full / empty; the
// caller checks the flags first. dout shows the top entry.
module pseq_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] sp;
    logic [PW-1:0] top_i;

    assign full  = (sp == PW'(DEPTH));
    assign empty = (sp == '0);
    assign top_i = sp - PW'(1);
    assign dout  = mem[top_i[AW-1:0]];

    // Stack pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        sp <= '0;
        else if (push && !full)   sp <= sp + PW'(1);
        else if (pop && !empty)   sp <= sp - PW'(1);
    end

    // Entry write on push.
    always_ff @(posedge clk) begin
        if (push && !full) mem[sp[AW-1:0]] <= din;
    end
endmodule

// File: rtl/pattern_seq.sv
// Step sequence controller top. Counts pattern cycles of the current step
// and, on the last one, executes the step's command to choose the next
// address. Assumes step_word is the memory content at step_addr in the
// same cycle (combinational read).
module pattern_seq
    import pseq_pkg::*;
#(
    parameter int STACK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start,
    input  logic              trig_bus_start,
    input  logic              ext_event_start,
    input  logic              ext_trig_start,
    input  logic              resume,
    input  logic              err_in,
    input  logic              tmo_in,
    input  logic              sig_in,
    input  logic [WORD_W-1:0] step_word,
    output logic [ADDR_W-1:0] step_addr,
    output logic              step_active,
    output logic              seq_active,
    output logic              seq_idle,
    output logic              sos_pulse,
    output logic              step_sync,
    output logic              err_halt
);
    step_t             w;
    st_e               st, nxt_st;
    logic [PLEN_W-1:0] pcnt;
    logic [ADDR_W-1:0] nxt_addr, addr_inc, stk_top;
    logic              start_any, begin_seq, last, hit, back;
    logic              push, pop, loop_ev, err_set, stk_full, stk_empty;

    assign w         = step_t'(step_word);
    assign start_any = sw_start | trig_bus_start | ext_event_start | ext_trig_start;
    assign begin_seq = (st == ST_IDLE) && start_any;
    assign last      = (pcnt == w.plen);
    assign addr_inc  = step_addr + ADDR_W'(1);

    pseq_cond u_cond (
        .clk(clk), .rst_n(rst_n), .err_in(err_in), .tmo_in(tmo_in),
        .sig_in(sig_in), .sel(w.cond), .hit(hit)
    );

    pseq_loops #(.N(NUM_LOOPS), .CW(CNT_W), .IW(CTR_W)) u_loops (
        .clk(clk), .rst_n(rst_n), .clr(begin_seq), .ev(loop_ev),
        .idx(w.ctr), .count(w.count), .back(back)
    );

    pseq_stack #(.DEPTH(STACK_DEPTH), .W(ADDR_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .clr(begin_seq), .push(push), .pop(pop),
        .din(addr_inc), .dout(stk_top), .full(stk_full), .empty(stk_empty)
    );

    // Next state and address; command execution on the last pattern cycle.
    always_comb begin
        nxt_st   = st;
        nxt_addr = step_addr;
        push     = 1'b0;
        pop      = 1'b0;
        loop_ev  = 1'b0;
        err_set  = 1'b0;
        case (st)
            ST_IDLE: if (start_any) begin
                nxt_st   = ST_RUN;
                nxt_addr = '0;
            end
            ST_RUN: if (last) begin
                case (w.op)
                    OP_NEXT: nxt_addr = addr_inc;
                    OP_JUMP: nxt_addr = w.target;
                    OP_CJMP: nxt_addr = hit ? w.target : addr_inc;
                    OP_LOOP: begin
                        loop_ev  = 1'b1;
                        nxt_addr = back ? w.target : addr_inc;
                    end
                    OP_CALL: if (stk_full) begin
                        err_set = 1'b1;
                        nxt_st  = ST_IDLE;
                    end else begin
                        push     = 1'b1;
                        nxt_addr = w.target;
                    end
                    OP_RET: if (stk_empty) begin
                        err_set = 1'b1;
                        nxt_st  = ST_IDLE;
                    end else begin
                        pop      = 1'b1;
                        nxt_addr = stk_top;
                    end
                    OP_PAUSE: nxt_st = ST_PAUSE;
                    default:  nxt_st = ST_IDLE;
                endcase
            end
            default: if (resume) begin
                nxt_st   = ST_RUN;
                nxt_addr = addr_inc;
            end
        endcase
    end

    // State, address, pattern counter and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            step_addr <= '0;
            pcnt      <= '0;
            sos_pulse <= 1'b0;
            step_sync <= 1'b0;
        end else begin
            st        <= nxt_st;
            step_addr <= nxt_addr;
            pcnt      <= (st == ST_RUN && !last) ? pcnt + PLEN_W'(1) : '0;
            sos_pulse <= begin_seq;
            step_sync <= (nxt_st == ST_RUN) && (st != ST_RUN || last);
        end
    end

    // Error flag: set on stack fault, cleared by the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_halt <= 1'b0;
        else if (err_set)   err_halt <= 1'b1;
        else if (begin_seq) err_halt <= 1'b0;
    end

    assign step_active = (st == ST_RUN);
    assign seq_active  = (st != ST_IDLE);
    assign seq_idle    = (st == ST_IDLE);
endmodule

// File: rtl/pseq_check.sv
// Cycle invariants of the step sequence controller, bound to its top.
module pseq_check (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] step_addr,
    input logic        step_active,
    input logic        seq_active,
    input logic        seq_idle,
    input logic        sos_pulse,
    input logic        step_sync,
    input logic        err_halt
);
    a_r2_sos_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sos_pulse |-> $past(seq_idle));
    a_r2_sos_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sos_pulse |-> (step_sync && step_addr == 12'd0));
    a_r3_addr_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_active && !step_sync) |-> $stable(step_addr));
    a_r8_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_active && !step_active) |-> $stable(step_addr));
    a_r10_sync_active: assert property (@(posedge clk) disable iff (!rst_n)
        step_sync |-> step_active);
    a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_halt |-> seq_idle);
    a_r1_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
        seq_idle |-> (!seq_active && !step_active));
endmodule

bind pattern_seq pseq_check u_chk (.*);

// File: tb/pattern_seq_test.sv
module pattern_seq_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, sw_start, trig_bus_start, ext_event_start, ext_trig_start;
    logic resume, err_in, tmo_in, sig_in;
    logic [63:0] step_word;
    logic [11:0] step_addr;
    logic step_active, seq_active, seq_idle, sos_pulse, step_sync, err_halt;

    pattern_seq uut (.*);

    logic [63:0] mem [int];
    int visits [int];
    int n_chk = 0, n_fail = 0;
    bit go = 0;

    function automatic logic [63:0] fetch(int a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] mk(int op, int tgt, int cnt, int ctr, int cnd, int plen);
        return {plen[25:0], cnd[2:0], ctr[3:0], cnt[15:0], tgt[11:0], op[2:0]};
    endfunction

    function automatic int vis(int a);
        if (visits.exists(a)) return visits[a];
        return 0;
    endfunction

    assign step_word = fetch(int'(step_addr));

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0, m_addr = 0, m_pcnt = 0;
    bit m_sos = 0, m_sync = 0, m_err = 0;
    int m_act [16], m_rem [16];
    int stk [$];
    bit s1 = 0, s2 = 0, s3 = 0;

    always @(posedge clk) begin
        logic [63:0] w;
        int op, tgt, cnt, ctr, cnd, plen, inc;
        bit hit, n_sos, n_sync;
        go = 1;
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_pcnt = 0; m_sos = 0; m_sync = 0; m_err = 0;
            foreach (m_act[i]) begin m_act[i] = 0; m_rem[i] = 0; end
            stk.delete(); s1 = 0; s2 = 0; s3 = 0;
        end else begin
            w = fetch(m_addr);
            op = int'(w[2:0]); tgt = int'(w[14:3]); cnt = int'(w[30:15]);
            ctr = int'(w[34:31]); cnd = int'(w[37:35]); plen = int'(w[63:38]);
            inc = (m_addr + 1) % 4096;
            case (cnd)
                0: hit = err_in;
                1: hit = tmo_in;
                2: hit = s2;
                3: hit = !s2;
                4: hit = s2 && !s3;
                5: hit = !s2 && s3;
                default: hit = 0;
            endcase
            n_sos = 0; n_sync = 0;
            if (m_st == 0) begin
                if (sw_start || trig_bus_start || ext_event_start || ext_trig_start) begin
                    m_st = 1; m_addr = 0; m_pcnt = 0; n_sos = 1; n_sync = 1; m_err = 0;
                    foreach (m_act[i]) begin m_act[i] = 0; m_rem[i] = 0; end
                    stk.delete();
                end
            end else if (m_st == 1) begin
                if (m_pcnt < plen) m_pcnt++;
                else begin
                    m_pcnt = 0; n_sync = 1;
                    case (op)
                        0: m_addr = inc;
                        1: m_addr = tgt;
                        2: m_addr = hit ? tgt : inc;
                        3: begin
                            if (cnt == 0) m_addr = tgt;
                            else if (m_act[ctr] == 0) begin
                                if (cnt == 1) m_addr = inc;
                                else begin m_act[ctr] = 1; m_rem[ctr] = cnt - 2; m_addr = tgt; end
                            end else if (m_rem[ctr] == 0) begin m_act[ctr] = 0; m_addr = inc; end
                            else begin m_rem[ctr]--; m_addr = tgt; end
                        end
                        4: if (stk.size() == 16) begin m_err = 1; m_st = 0; n_sync = 0; end
                           else begin stk.push_back(inc); m_addr = tgt; end
                        5: if (stk.size() == 0) begin m_err = 1; m_st = 0; n_sync = 0; end
                           else m_addr = stk.pop_back();
                        6: begin m_st = 2; n_sync = 0; end
                        default: begin m_st = 0; n_sync = 0; end
                    endcase
                end
            end else if (resume) begin
                m_st = 1; m_addr = inc; n_sync = 1;
            end
            m_sos = n_sos; m_sync = n_sync;
            s3 = s2; s2 = s1; s1 = sig_in;
        end
    end

    // Compare design against model every cycle, away from the clock edge.
    always @(negedge clk) if (go) begin
        chk("R3 step_addr", int'(step_addr), m_addr);
        chk("R1 seq_idle", int'(seq_idle), int'(m_st == 0));
        chk("R1 seq_active", int'(seq_active), int'(m_st != 0));
        chk("R8 step_active", int'(step_active), int'(m_st == 1));
        chk("R10 step_sync", int'(step_sync), int'(m_sync));
        chk("R2 sos_pulse", int'(sos_pulse), int'(m_sos));
        chk("R7 err_halt", int'(err_halt), int'(m_err));
        if (step_sync) visits[int'(step_addr)] = vis(int'(step_addr)) + 1;
    end

    task automatic start_seq(int src);
        visits.delete();
        @(negedge clk);
        case (src)
            0: sw_start = 1;
            1: trig_bus_start = 1;
            2: ext_event_start = 1;
            default: ext_trig_start = 1;
        endcase
        @(negedge clk);
        sw_start = 0; trig_bus_start = 0; ext_event_start = 0; ext_trig_start = 0;
    endtask

    task automatic wait_idle();
        while (!seq_idle) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 0; sw_start = 0; trig_bus_start = 0; ext_event_start = 0; ext_trig_start = 0;
        resume = 0; err_in = 0; tmo_in = 0; sig_in = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset addr", int'(step_addr), 0);
        chk("R1 reset idle", int'(seq_idle), 1);
        chk("R1 reset err", int'(err_halt), 0);
        rst_n = 1;
        @(negedge clk);

        // R3 R4 R6 R9: simple loop, jump, halt
        mem.delete();
        mem[0] = mk(0, 0, 0, 0, 0, 2);
        mem[1] = mk(3, 0, 3, 0, 0, 0);
        mem[2] = mk(1, 5, 0, 0, 0, 0);
        mem[5] = mk(7, 0, 0, 0, 0, 1);
        start_seq(0);
        wait_idle();
        chk("R6 loop body runs", vis(0), 3);
        chk("R6 loop end visits", vis(1), 3);
        chk("R4 jump skips 3", vis(3), 0);
        chk("R9 halt keeps addr", int'(step_addr), 5);

        // R6 nested loops, R2 start ignored while running
        mem.delete();
        mem[0] = mk(0, 0, 0, 0, 0, 0);
        mem[1] = mk(3, 1, 2, 1, 0, 0);
        mem[2] = mk(3, 0, 3, 2, 0, 0);
        mem[3] = mk(7, 0, 0, 0, 0, 0);
        start_seq(1);
        repeat (3) @(negedge clk);
        sw_start = 1; @(negedge clk); sw_start = 0;
        wait_idle();
        chk("R6 outer body", vis(0), 3);
        chk("R6 inner rearm", vis(1), 6);
        chk("R2 restart ignored", vis(3), 1);

        // R7 call / return
        mem.delete();
        mem[0] = mk(4, 10, 0, 0, 0, 0);
        mem[1] = mk(7, 0, 0, 0, 0, 0);
        mem[10] = mk(0, 0, 0, 0, 0, 1);
        mem[11] = mk(5, 0, 0, 0, 0, 0);
        start_seq(2);
        wait_idle();
        chk("R7 sub entered", vis(11), 1);
        chk("R7 returned", vis(1), 1);
        chk("R7 no error", int'(err_halt), 0);

        // R7 underflow
        mem.delete();
        mem[0] = mk(5, 0, 0, 0, 0, 0);
        start_seq(3);
        wait_idle();
        chk("R7 underflow err", int'(err_halt), 1);

        // R7 overflow after 16 calls
        mem.delete();
        mem[0] = mk(4, 0, 0, 0, 0, 0);
        start_seq(0);
        wait_idle();
        chk("R7 overflow depth", vis(0), 17);
        chk("R7 overflow err", int'(err_halt), 1);

        // R8 pause, R2 error cleared on start
        mem.delete();
        mem[0] = mk(6, 0, 0, 0, 0, 1);
        mem[1] = mk(7, 0, 0, 0, 0, 0);
        start_seq(0);
        chk("R2 err cleared", int'(err_halt), 0);
        repeat (10) @(negedge clk);
        chk("R8 paused addr", int'(step_addr), 0);
        chk("R8 paused inactive", int'(step_active), 0);
        chk("R8 paused seq", int'(seq_active), 1);
        resume = 1; @(negedge clk); resume = 0;
        wait_idle();
        chk("R8 resumed", vis(1), 1);

        // R5 level conditions, error, timeout
        mem.delete();
        mem[1] = mk(7, 0, 0, 0, 0, 0);
        mem[4] = mk(7, 0, 0, 0, 0, 0);
        sig_in = 1; repeat (4) @(negedge clk);
        mem[0] = mk(2, 4, 0, 0, 2, 3);
        start_seq(0); wait_idle();
        chk("R5 high taken", vis(4), 1);
        mem[0] = mk(2, 4, 0, 0, 3, 3);
        start_seq(0); wait_idle();
        chk("R5 low not taken", vis(1), 1);
        mem[0] = mk(2, 4, 0, 0, 4, 3);
        start_seq(0); wait_idle();
        chk("R11 steady no edge", vis(1), 1);
        sig_in = 0; repeat (4) @(negedge clk);
        mem[0] = mk(2, 4, 0, 0, 3, 3);
        start_seq(0); wait_idle();
        chk("R5 low taken", vis(4), 1);
        err_in = 1;
        mem[0] = mk(2, 4, 0, 0, 0, 0);
        start_seq(0); wait_idle();
        chk("R5 error taken", vis(4), 1);
        err_in = 0;
        mem[0] = mk(2, 4, 0, 0, 1, 0);
        start_seq(0); wait_idle();
        chk("R5 timeout low", vis(1), 1);
        mem[0] = mk(2, 4, 0, 0, 6, 0);
        start_seq(0); wait_idle();
        chk("R5 code 6 never", vis(1), 1);

        // R11 edges: step 0 lasts 10 cycles, step 1 decides on edge
        mem.delete();
        mem[0] = mk(0, 0, 0, 0, 0, 9);
        mem[1] = mk(2, 4, 0, 0, 4, 0);
        mem[2] = mk(7, 0, 0, 0, 0, 0);
        mem[4] = mk(7, 0, 0, 0, 0, 0);
        start_seq(0);
        repeat (8) @(negedge clk); sig_in = 1;
        wait_idle();
        chk("R11 rise hit", vis(4), 1);
        mem[1] = mk(2, 4, 0, 0, 5, 0);
        start_seq(0);
        repeat (8) @(negedge clk); sig_in = 0;
        wait_idle();
        chk("R11 fall hit", vis(4), 1);
        mem[1] = mk(2, 4, 0, 0, 4, 0);
        start_seq(0);
        repeat (7) @(negedge clk); sig_in = 1;
        wait_idle();
        chk("R11 early edge missed", vis(2), 1);
        sig_in = 0; repeat (4) @(negedge clk);

        // R6 continuous loop, then R1 reset stops it
        mem.delete();
        mem[1] = mk(3, 0, 0, 3, 0, 0);
        start_seq(0);
        repeat (20) @(negedge clk);
        chk("R6 continuous active", int'(seq_active), 1);
        chk("R6 continuous no exit", vis(2), 0);
        chk("R6 continuous repeats", int'(vis(0) >= 5), 1);
        rst_n = 0; repeat (2) @(negedge clk);
        chk("R1 reset stops", int'(seq_idle), 1);
        chk("R1 reset addr0", int'(step_addr), 0);
        rst_n = 1; repeat (2) @(negedge clk);

        finish_run();
    end
endmodule